// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a virtual page number into a physical address by walking a hashed, chained translation structure that lives in ordinary memory. A lookup request carries a virtual page, a byte offset and a read/write flag. The walker folds the page number into an index and reads the head pointer for that bucket from an anchor table. It then follows a singly linked chain of translation entries. Each entry holds a virtual tag, an explicit frame number, a link to the next entry and a write-permission bit.

Because the frame number is stored in the entry and not implied by the entry's position, any number of virtual pages may point at one frame, each with its own permission. On a tag match the walker performs a read-modify-write of that frame's word in a separate frame table. This marks the frame as referenced and, for writes, as modified. It then returns the frame number joined to the request offset. When a walk fails, the walker returns a fault code instead: a missing page, a permission violation, or a chain that ran past a programmable length bound.

All table traffic uses one shared memory port with one access outstanding. The anchor table size and the three table base addresses are configuration inputs that are held stable while the walker is busy.

Top module: `hpw_walker`

## Requirements
- R1: The anchor index is (vpn XOR (vpn >> B)) masked to its low B bits, where B is cfgAnchorBits (12 to 20). The anchor word is read at cfgAnchorBase + index, and its bits [19:0] hold the head pointer.
- R2: An anchor head pointer of all ones (20'hFFFFF) ends the walk with fault code 1 (page fault) and no write to memory.
- R3: The chain entry for pointer p is read at cfgChainBase + p. Its layout is tag [19:0], frame [39:20], next [59:40] and write-permit [60]. When the tag differs from the requested page, the walk continues at the next pointer.
- R4: On a tag match with access allowed, the response has fault code 0 and rspAddr = {frame, offset}.
- R5: On an allowed hit, the frame word at cfgFrameBase + frame is read and written back with bit 0 (referenced) set. For a write access, bit 1 (changed) is also set. All other bits are preserved.
- R6: A mismatching entry whose next pointer is all ones ends the walk with fault code 1.
- R7: Entries that alias one frame are checked independently: each applies its own write-permit bit.
- R8: A write access that matches an entry whose write-permit bit is 0 returns fault code 2 (protection). The frame word is left unchanged.
- R9: If the cfgMaxChain-th chain entry read does not match and is not the end of the chain, the walk stops with fault code 3 (chain error).
- R10: reqReady is high only while idle. Each accepted request yields exactly one single-cycle rspValid pulse. A memory request holds its address and direction until it is acknowledged.
- R11: After reset the walker is idle: reqReady is 1, and rspValid and memReq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVpn | input | 20 | Virtual page number |
| reqOff | input | 12 | Byte offset in page |
| reqWrite | input | 1 | 1 for write access |
| cfgAnchorBits | input | 5 | log2 of anchor table entries (12..20) |
| cfgAnchorBase | input | 32 | Anchor table word address |
| cfgChainBase | input | 32 | Chain entry table word address |
| cfgFrameBase | input | 32 | Frame table word address |
| cfgMaxChain | input | 8 | Maximum chain entries read per walk (at least 1) |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWrite | output | 1 | 1 for write access |
| memAddr | output | 32 | Word address |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | One-cycle access completion |
| memRdata | input | 64 | Read data, valid with memAck |
| rspValid | output | 1 | One-cycle response strobe |
| rspAddr | output | 32 | Physical address {frame, offset} |
| rspFault | output | 2 | 0 ok, 1 page fault, 2 protection, 3 chain error |

## Verification
The assertions watch the port-level protocol on every cycle. They check that memory requests stay steady until acknowledged, that no request is issued while idle, that every frame write sets the referenced bit, that a success response directly follows an acknowledged frame write, and that a fault response never directly follows a write. Only the bench scenarios can show the walk results themselves. These are the hash indexing, following chains through colliding pages, aliased frames with differing permissions, an untouched frame word after a protection fault, and the chain bound stopping a self-linked loop. The bench compares each of these against a reference walk over its own copy of the tables.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ANCHOR, ST_CHAIN, ST_FRAME_RD, ST_FRAME_WR, ST_RESP
  } walkState_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_PAGE = 2'd1, FLT_PROT = 2'd2, FLT_CHAIN = 2'd3
  } fault_t;

  typedef enum logic [1:0] {
    SEL_ANCHOR, SEL_CHAIN, SEL_FRAME
  } addrSel_t;

  typedef struct packed {
    logic     loadReq;
    logic     loadPtr;
    logic     loadEntry;
    logic     loadFrame;
    logic     memReq;
    logic     memWrite;
    addrSel_t addrSel;
  } strobes_t;

  typedef struct packed {
    logic anchorNull;
    logic tagHit;
    logic nextNull;
    logic wrDenied;
    logic cntLast;
  } status_t;
endpackage

// File: rtl/hpw_ctrl.sv
module hpw_ctrl
  import hpw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memAck,
  input  status_t  stat,
  output strobes_t stb,
  output logic     reqReady,
  output logic     rspValid,
  output logic [1:0] rspFault
);
  walkState_t state, nextState;
  fault_t     faultReg, nextFault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      faultReg <= FLT_NONE;
    end else begin
      state    <= nextState;
      faultReg <= nextFault;
    end
  end

  always_comb begin
    stb       = '0;
    stb.addrSel = SEL_ANCHOR;
    nextState = state;
    nextFault = faultReg;
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.loadReq = 1'b1;
        nextFault   = FLT_NONE;
        nextState   = ST_ANCHOR;
      end
      ST_ANCHOR: begin
        stb.memReq = 1'b1;
        if (memAck) begin
          if (stat.anchorNull) begin
            nextFault = FLT_PAGE;
            nextState = ST_RESP;
          end else begin
            stb.loadPtr = 1'b1;
            nextState   = ST_CHAIN;
          end
        end
      end
      ST_CHAIN: begin
        stb.memReq  = 1'b1;
        stb.addrSel = SEL_CHAIN;
        if (memAck) begin
          stb.loadEntry = 1'b1;
          if (stat.tagHit) begin
            if (stat.wrDenied) begin
              nextFault = FLT_PROT;
              nextState = ST_RESP;
            end else begin
              nextState = ST_FRAME_RD;
            end
          end else if (stat.nextNull) begin
            nextFault = FLT_PAGE;
            nextState = ST_RESP;
          end else if (stat.cntLast) begin
            nextFault = FLT_CHAIN;
            nextState = ST_RESP;
          end
        end
      end
      ST_FRAME_RD: begin
        stb.memReq  = 1'b1;
        stb.addrSel = SEL_FRAME;
        if (memAck) begin
          stb.loadFrame = 1'b1;
          nextState     = ST_FRAME_WR;
        end
      end
      ST_FRAME_WR: begin
        stb.memReq   = 1'b1;
        stb.memWrite = 1'b1;
        stb.addrSel  = SEL_FRAME;
        if (memAck) begin
          nextFault = FLT_NONE;
          nextState = ST_RESP;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign rspFault = faultReg;
endmodule

// File: rtl/hpw_datapath.sv
module hpw_datapath
  import hpw_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int PTR_W  = 20,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [VPN_W-1:0]  reqVpn,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic              reqWrite,
  input  logic [4:0]        cfgAnchorBits,
  input  logic [ADDR_W-1:0] cfgAnchorBase,
  input  logic [ADDR_W-1:0] cfgChainBase,
  input  logic [ADDR_W-1:0] cfgFrameBase,
  input  logic [CNT_W-1:0]  cfgMaxChain,
  input  logic [DATA_W-1:0] memRdata,
  output status_t           stat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [PFN_W+OFF_W-1:0] physAddr
);
  localparam int PFN_LSB = VPN_W;
  localparam int NXT_LSB = VPN_W + PFN_W;
  localparam int WP_BIT  = VPN_W + PFN_W + PTR_W;

  logic [VPN_W-1:0]  vpnReg;
  logic [OFF_W-1:0]  offReg;
  logic              wrReg;
  logic [PTR_W-1:0]  ptrReg;
  logic [PFN_W-1:0]  frameReg;
  logic [CNT_W-1:0]  cntReg;
  logic [DATA_W-1:0] frameWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnReg <= '0; offReg <= '0; wrReg <= 1'b0;
      ptrReg <= '0; frameReg <= '0; cntReg <= '0; frameWord <= '0;
    end else begin
      if (stb.loadReq) begin
        vpnReg <= reqVpn;
        offReg <= reqOff;
        wrReg  <= reqWrite;
        cntReg <= '0;
      end
      if (stb.loadPtr) ptrReg <= memRdata[PTR_W-1:0];
      if (stb.loadEntry) begin
        ptrReg   <= memRdata[NXT_LSB +: PTR_W];
        frameReg <= memRdata[PFN_LSB +: PFN_W];
        cntReg   <= cntReg + 1'b1;
      end
      if (stb.loadFrame) frameWord <= memRdata;
    end
  end

  // XOR-fold of the page number, masked to the configured bucket count
  logic [VPN_W-1:0] folded, bucketMask, hashIdx;
  always_comb begin
    folded     = vpnReg ^ (vpnReg >> cfgAnchorBits);
    bucketMask = (VPN_W'(1) << cfgAnchorBits) - VPN_W'(1);
    hashIdx    = folded & bucketMask;
  end

  always_comb begin
    case (stb.addrSel)
      SEL_CHAIN: memAddr = cfgChainBase + ADDR_W'(ptrReg);
      SEL_FRAME: memAddr = cfgFrameBase + ADDR_W'(frameReg);
      default:   memAddr = cfgAnchorBase + ADDR_W'(hashIdx);
    endcase
  end

  assign memWdata = frameWord | DATA_W'(1) | (DATA_W'(wrReg) << 1);
  assign physAddr = {frameReg, offReg};

  always_comb begin
    stat.anchorNull = &memRdata[PTR_W-1:0];
    stat.tagHit     = (memRdata[VPN_W-1:0] == vpnReg);
    stat.nextNull   = &memRdata[NXT_LSB +: PTR_W];
    stat.wrDenied   = wrReg & ~memRdata[WP_BIT];
    stat.cntLast    = ({1'b0, cntReg} + 1'b1) >= {1'b0, cfgMaxChain};
  end
endmodule

// File: rtl/hpw_walker.sv
module hpw_walker
  import hpw_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int PTR_W  = 20,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VPN_W-1:0]  reqVpn,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic              reqWrite,
  input  logic [4:0]        cfgAnchorBits,
  input  logic [ADDR_W-1:0] cfgAnchorBase,
  input  logic [ADDR_W-1:0] cfgChainBase,
  input  logic [ADDR_W-1:0] cfgFrameBase,
  input  logic [CNT_W-1:0]  cfgMaxChain,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rspValid,
  output logic [PFN_W+OFF_W-1:0] rspAddr,
  output logic [1:0]        rspFault
);
  strobes_t stb;
  status_t  stat;

  hpw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .stat(stat), .stb(stb), .reqReady(reqReady), .rspValid(rspValid),
    .rspFault(rspFault)
  );

  hpw_datapath #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .PTR_W(PTR_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVpn(reqVpn), .reqOff(reqOff),
    .reqWrite(reqWrite), .cfgAnchorBits(cfgAnchorBits),
    .cfgAnchorBase(cfgAnchorBase), .cfgChainBase(cfgChainBase),
    .cfgFrameBase(cfgFrameBase), .cfgMaxChain(cfgMaxChain),
    .memRdata(memRdata), .stat(stat), .memAddr(memAddr),
    .memWdata(memWdata), .physAddr(rspAddr)
  );

  assign memReq   = stb.memReq;
  assign memWrite = stb.memWrite;
endmodule

// File: rtl/hpw_walker_chk.sv
module hpw_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memReq,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic              rspValid,
  input logic [1:0]        rspFault
);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  a_r5_ref_set: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> memWdata[0]);

  a_r4_ok_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd0) |-> $past(memReq && memWrite && memAck));

  a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> !$past(memWrite));
endmodule

bind hpw_walker hpw_walker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .memReq(memReq),
  .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
  .memAck(memAck), .rspValid(rspValid), .rspFault(rspFault)
);

// File: tb/tb_hpw_walker.sv
module tb_hpw_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic        reqReady;
  logic [19:0] reqVpn = '0;
  logic [11:0] reqOff = '0;
  logic [4:0]  cfgAnchorBits = 5'd12;
  logic [31:0] cfgAnchorBase = 32'h0001_0000;
  logic [31:0] cfgChainBase  = 32'h0020_0000;
  logic [31:0] cfgFrameBase  = 32'h0040_0000;
  logic [7:0]  cfgMaxChain   = 8'd16;
  logic        memReq, memWrite;
  logic [31:0] memAddr;
  logic [63:0] memWdata;
  logic        memAck = 1'b0;
  logic [63:0] memRdata = '0;
  logic        rspValid;
  logic [31:0] rspAddr;
  logic [1:0]  rspFault;

  hpw_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVpn(reqVpn), .reqOff(reqOff), .reqWrite(reqWrite),
    .cfgAnchorBits(cfgAnchorBits), .cfgAnchorBase(cfgAnchorBase),
    .cfgChainBase(cfgChainBase), .cfgFrameBase(cfgFrameBase),
    .cfgMaxChain(cfgMaxChain), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .rspValid(rspValid), .rspAddr(rspAddr),
    .rspFault(rspFault)
  );

  int checks = 0, errors = 0;
  logic [63:0] mem [logic [31:0]];
  int unsigned nextFree = 0;
  localparam logic [19:0] NULLP = 20'hFFFFF;

  function automatic logic [63:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : '1;
  endfunction

  function automatic logic [19:0] hashOf(input logic [19:0] v, input int ab);
    logic [19:0] f = v ^ (v >> ab);
    return f & ((20'd1 << ab) - 20'd1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic insert(input logic [19:0] v, input logic [19:0] pfn, input bit wp);
    logic [19:0] h = hashOf(v, int'(cfgAnchorBits));
    logic [19:0] head = rd(cfgAnchorBase + 32'(h))[19:0];
    mem[cfgChainBase + nextFree] = {3'b0, wp, head, pfn, v};
    mem[cfgAnchorBase + 32'(h)] = {44'd0, 20'(nextFree)};
    nextFree++;
  endtask

  // Reference walk: returns fault code and matched frame
  task automatic refWalk(input logic [19:0] v, input bit wr,
                         output int flt, output logic [19:0] pfn);
    logic [19:0] p = rd(cfgAnchorBase + 32'(hashOf(v, int'(cfgAnchorBits))))[19:0];
    int cnt = 0;
    pfn = '0;
    if (p == NULLP) begin flt = 1; return; end
    forever begin
      logic [63:0] e = rd(cfgChainBase + 32'(p));
      cnt++;
      if (e[19:0] == v) begin
        pfn = e[39:20];
        flt = (wr && !e[60]) ? 2 : 0;
        return;
      end
      if (e[59:40] == NULLP) begin flt = 1; return; end
      if (cnt >= int'(cfgMaxChain)) begin flt = 3; return; end
      p = e[59:40];
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        repeat ($urandom % 3) @(negedge clk);
        memRdata = rd(memAddr);
        if (memWrite) mem[memAddr] = memWdata;
        memAck = 1'b1;
      end
    end
  end

  task automatic lookup(input logic [19:0] v, input logic [11:0] off, input bit wr,
                        input string req);
    int flt; logic [19:0] pfn; logic [63:0] oldF, expF; int n = 0;
    refWalk(v, wr, flt, pfn);
    oldF = rd(cfgFrameBase + 32'(pfn));
    @(negedge clk);
    reqVpn = v; reqOff = off; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid && n < 1000) begin @(negedge clk); n++; end
    check(rspValid, {req, " response"}, 64'(rspValid), 64'd1);
    check(rspFault == 2'(flt), {req, " fault"}, 64'(rspFault), 64'(flt));
    if (flt == 0) begin
      check(rspAddr == {pfn, off}, {req, " R4 addr"}, 64'(rspAddr), 64'({pfn, off}));
      expF = oldF | 64'd1 | (wr ? 64'd2 : 64'd0);
      check(rd(cfgFrameBase + 32'(pfn)) == expF, {req, " R5 frame"},
            rd(cfgFrameBase + 32'(pfn)), expF);
    end else if (flt == 2) begin
      check(rd(cfgFrameBase + 32'(pfn)) == oldF, {req, " R8 frame kept"},
            rd(cfgFrameBase + 32'(pfn)), oldF);
    end
    @(negedge clk);
    check(!rspValid && reqReady, {req, " R10 pulse"}, 64'({rspValid, reqReady}), 64'b01);
  endtask

  function automatic logic [19:0] collide(input logic [19:0] v, input logic [19:0] k,
                                          input int ab);
    return v ^ (k << ab) ^ k;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] va, vb, vc, vd;
    logic [19:0] used [64];
    void'($urandom(32'd4242));
    for (int f = 0; f < 64; f++)
      mem[cfgFrameBase + f] = {$urandom, $urandom} & ~64'd3;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(reqReady && !rspValid && !memReq, "R11 reset idle",
          64'({reqReady, rspValid, memReq}), 64'b100);
    rstN = 1'b1;
    @(negedge clk);

    // R2: empty bucket
    lookup(20'h12345, 12'h001, 1'b0, "R2 empty anchor");

    // R1 R4 R5: single hit, read then write
    va = 20'h0A5C3;
    insert(va, 20'd7, 1'b1);
    lookup(va, 12'hABC, 1'b0, "R1 R4 R5 read hit");
    lookup(va, 12'h123, 1'b1, "R5 write hit");

    // R3 R6: colliding pages, walk past head; unknown colliding page
    vb = collide(va, 20'd3, 12);
    vc = collide(va, 20'd5, 12);
    insert(vb, 20'd9, 1'b1);
    lookup(va, 12'h010, 1'b0, "R3 second in chain");
    lookup(vb, 12'h020, 1'b1, "R3 head of chain");
    lookup(vc, 12'h030, 1'b0, "R6 chain end miss");

    // R7 R8: alias of frame 7, read-only
    vd = collide(va, 20'd6, 12);
    insert(vd, 20'd7, 1'b0);
    lookup(vd, 12'h040, 1'b1, "R8 write to read-only alias");
    lookup(vd, 12'h050, 1'b0, "R7 read through read-only alias");
    lookup(va, 12'h060, 1'b1, "R7 writable alias same frame");

    // R9: self-linked entry with foreign tag
    mem[cfgAnchorBase + 32'(hashOf(20'h00777, 12))] = 64'd5000;
    mem[cfgChainBase + 5000] = {3'b0, 1'b1, 20'd5000, 20'd1, 20'h00778 ^ 20'h01000};
    cfgMaxChain = 8'd4;
    lookup(20'h00777, 12'h0, 1'b0, "R9 looped chain");
    cfgMaxChain = 8'd1;
    lookup(vc, 12'h0, 1'b0, "R9 limit one");
    cfgMaxChain = 8'd16;

    // R1: fresh tables with a larger bucket count, random traffic
    cfgAnchorBits = 5'd14;
    cfgAnchorBase = 32'h0080_0000;
    cfgChainBase  = 32'h00A0_0000;
    nextFree = 0;
    for (int i = 0; i < 64; i++) begin
      logic [19:0] v = (i % 4 == 3) ? collide(used[i-1], 20'(i % 60 + 1), 14)
                                     : 20'($urandom);
      used[i] = v;
      insert(v, 20'($urandom % 64), 1'($urandom % 2));
    end
    for (int i = 0; i < 200; i++) begin
      logic [19:0] v = ($urandom % 4 == 0) ? 20'($urandom) : used[$urandom % 64];
      lookup(v, 12'($urandom), 1'($urandom % 2), "R1 R3 R4 R5 R6 R7 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule